// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Plane

This block is a soft sum-of-products logic plane. Eight dedicated input bits and eight feedback bits are each expanded into a true line and a complement line, giving 32 input lines. A configuration store holds one 32-bit connection word per product term, 64 terms in all. Each product term is the AND of the lines its word selects. The terms are ORed in fixed groups to produce eight sum outputs. Each output also owns one spare term.

A single mode input decides how the spare terms are used, for all outputs at once. In one setting each spare term becomes an eighth member of its output's OR. In the other it is presented on its own output as an enable term. Software-style loading is done one term at a time through a write port. A readback port returns any stored word. An erase strobe opens every connection.

Evaluation from the inputs and the stored words to the sum and enable outputs is purely combinational. Only the configuration store is clocked.

Top module: `sop_plane`

## Requirements
- R1: Input line 2k carries the true value of signal k and line 2k+1 its complement. Signals 0 to 7 are `ded_in[0..7]` and signals 8 to 15 are `fb_in[0..7]`.
- R2: Bit j of a term's connection word set means line j is ANDed into that term. The term is the AND of all connected lines.
- R3: A term whose connection word is all zero evaluates TRUE.
- R4: A term connected to both the true and complement line of one signal evaluates FALSE whatever the inputs.
- R5: Output o owns terms 8o to 8o+6 as its OR group and term 8o+7 as its spare. A true term affects only its own output.
- R6: With `spare_join` = 1, `sum_out[o]` is the OR of all eight terms of output o, and `oe_term[o]` is 0.
- R7: With `spare_join` = 0, `sum_out[o]` is the OR of the seven group terms only, and `oe_term[o]` equals the spare term.
- R8: A cycle with `wr_en` high stores `wr_word` at term `wr_idx` at that clock edge. `rd_word` shows the stored word of term `rd_idx` combinationally.
- R9: A cycle with `erase` high clears every connection word at that clock edge. Erase wins over a write in the same cycle.
- R10: A clock edge with `rst_n` low clears every connection word.
- R11: A change on `ded_in`, `fb_in` or `spare_join` reaches `sum_out` and `oe_term` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset; clears the store |
| ded_in | input | 8 | Dedicated input signals |
| fb_in | input | 8 | Feedback or pin signals |
| spare_join | input | 1 | 1: spare term joins the OR; 0: spare term drives `oe_term` |
| wr_en | input | 1 | Write strobe for one connection word |
| wr_idx | input | 6 | Term index to write |
| wr_word | input | 32 | Connection word to store |
| erase | input | 1 | Clears all connection words |
| rd_idx | input | 6 | Term index to read back |
| rd_word | output | 32 | Stored connection word of `rd_idx` |
| sum_out | output | 8 | Sum-of-products outputs |
| oe_term | output | 8 | Spare-term outputs, used as enables |

## Verification
A corrupted connection bit shows at the ports right away. `rd_word` reveals it on the first cycle the bad index is addressed. The sum or enable of the owning output shows it as soon as the input pattern lets that bit decide the term. A misrouted line or a wrong group boundary flips a sum output in the same cycle the inputs change, since nothing between the store and the outputs is registered. The reference model is compared with all three outputs on every clock, so a mismatch is reported within the cycle that exposes it.

// File: rtl/sop_pkg.sv
// Shared definitions for the product-term plane.
// Assumes: the spare-term mode is global to all outputs.
package sop_pkg;
    // How the per-output spare term is used
    typedef enum logic {
        SPARE_AS_OE = 1'b0,
        SPARE_IN_OR = 1'b1
    } spare_mode_e;

    // Index of the line carrying signal sig in the requested polarity
    function automatic int line_of(input int sig, input logic inverted);
        return 2 * sig + (inverted ? 1 : 0);
    endfunction
endpackage

// File: rtl/sop_line_build.sv
// Builds the true/complement input lines from dedicated and feedback signals.
// Assumes: dedicated signals come first in the signal numbering.
module sop_line_build #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    localparam int N_SIG   = N_DED + N_FB,
    localparam int N_LINES = 2 * N_SIG
) (
    input  logic [N_DED-1:0]   ded_i,
    input  logic [N_FB-1:0]    fb_i,
    output logic [N_LINES-1:0] lines_o
);
    logic [N_SIG-1:0] sig;

    assign sig = {fb_i, ded_i};

    // one true and one complement line per signal
    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        assign lines_o[sop_pkg::line_of(s, 1'b0)] = sig[s];
        assign lines_o[sop_pkg::line_of(s, 1'b1)] = ~sig[s];
    end
endmodule

// File: rtl/sop_cfg_store.sv
// Connection-word store: one word per product term, row write, erase, readback.
// Assumes: erase takes priority over a same-cycle write; reset is synchronous.
module sop_cfg_store #(
    parameter int N_TERMS = 64,
    parameter int N_LINES = 32,
    localparam int IDX_W  = $clog2(N_TERMS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [IDX_W-1:0]           wr_idx_i,
    input  logic [N_LINES-1:0]         wr_word_i,
    input  logic                       erase_i,
    input  logic [IDX_W-1:0]           rd_idx_i,
    output logic [N_LINES-1:0]         rd_word_o,
    output logic [N_TERMS*N_LINES-1:0] masks_o
);
    localparam logic [IDX_W:0] TERM_LIMIT = N_TERMS;

    logic [N_LINES-1:0] mem_q [N_TERMS];
    logic               wr_ok;
    logic               rd_ok;

    assign wr_ok = wr_en_i && ({1'b0, wr_idx_i} < TERM_LIMIT);
    assign rd_ok = {1'b0, rd_idx_i} < TERM_LIMIT;

    // reset and erase open every connection; otherwise store one row
    always_ff @(posedge clk) begin
        if (!rst_n || erase_i) begin
            for (int t = 0; t < N_TERMS; t++) begin
                mem_q[t] <= '0;
            end
        end else if (wr_ok) begin
            mem_q[wr_idx_i] <= wr_word_i;
        end
    end

    // combinational readback of one row
    always_comb begin
        rd_word_o = '0;
        if (rd_ok) begin
            rd_word_o = mem_q[rd_idx_i];
        end
    end

    // flatten rows for the evaluator
    for (genvar t = 0; t < N_TERMS; t++) begin : g_flat
        assign masks_o[t*N_LINES +: N_LINES] = mem_q[t];
    end

    // R8: a written row is visible at its index on the next cycle
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !erase_i) |=>
            ((rd_idx_i != $past(wr_idx_i)) || (rd_word_o == $past(wr_word_i))));

    // R9: after an erase every row reads back empty
    p_erase_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (rd_word_o == '0));

    // R10: first cycle out of reset every row is empty
    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_word_o == '0));
endmodule

// File: rtl/sop_term_eval.sv
// Evaluates every product term as the AND of its connected lines.
// Assumes: a set connection bit means the line is ANDed in; an open term is TRUE.
module sop_term_eval #(
    parameter int N_TERMS = 64,
    parameter int N_LINES = 32,
    localparam int N_PAIRS = N_LINES / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES-1:0]         lines_i,
    input  logic [N_TERMS*N_LINES-1:0] masks_i,
    output logic [N_TERMS-1:0]         terms_o
);
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [N_LINES-1:0] mask;
        logic               conflict;

        assign mask = masks_i[t*N_LINES +: N_LINES];

        // unconnected lines are forced high before the wide AND
        assign terms_o[t] = &(lines_i | ~mask);

        // flags a term tied to both polarities of one signal
        always_comb begin
            conflict = 1'b0;
            for (int p = 0; p < N_PAIRS; p++) begin
                conflict = conflict | (mask[2*p] & mask[2*p+1]);
            end
        end

        // R3: an open term is TRUE
        p_open_true_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (mask == '0) |-> terms_o[t]);

        // R4: a term holding both polarities of a signal is FALSE
        p_conflict_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
            conflict |-> !terms_o[t]);
    end
endmodule

// File: rtl/sop_or_groups.sv
// Fixed OR groups per output plus spare-term routing.
// Assumes: output o owns GRP_TERMS consecutive terms followed by its spare term.
module sop_or_groups
    import sop_pkg::*;
#(
    parameter int N_OUT     = 8,
    parameter int GRP_TERMS = 7,
    localparam int TPO      = GRP_TERMS + 1,
    localparam int N_TERMS  = N_OUT * TPO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spare_join_i,
    input  logic [N_TERMS-1:0] terms_i,
    output logic [N_OUT-1:0]   sum_o,
    output logic [N_OUT-1:0]   oe_o
);
    spare_mode_e mode;

    assign mode = spare_mode_e'(spare_join_i);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [GRP_TERMS-1:0] grp;
        logic                 spare;

        assign grp   = terms_i[o*TPO +: GRP_TERMS];
        assign spare = terms_i[o*TPO + GRP_TERMS];

        // OR the group and, in join mode, the spare term
        always_comb begin
            sum_o[o] = |grp;
            oe_o[o]  = 1'b0;
            if (mode == SPARE_IN_OR) begin
                sum_o[o] = sum_o[o] | spare;
            end else begin
                oe_o[o] = spare;
            end
        end

        // R5: any true group term drives its own sum
        p_group_sets_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (|grp) |-> sum_o[o]);

        // R6: join mode keeps the enable quiet and lets the spare set the sum
        p_join_quiet_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
            spare_join_i |-> (!oe_o[o] && (!spare || sum_o[o])));

        // R7: enable mode shows the spare term and keeps it out of the sum
        p_oe_follows_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !spare_join_i |-> ((oe_o[o] == spare) && (sum_o[o] == (|grp))));
    end
endmodule

// File: rtl/sop_plane.sv
// Top of the programmable AND-OR plane: line builder, configuration store,
// term evaluator and fixed OR groups.
// Assumes: only the store is clocked; evaluation is combinational end to end.
module sop_plane #(
    parameter int N_DED     = 8,
    parameter int N_FB      = 8,
    parameter int N_OUT     = 8,
    parameter int GRP_TERMS = 7,
    localparam int N_LINES  = 2 * (N_DED + N_FB),
    localparam int N_TERMS  = N_OUT * (GRP_TERMS + 1),
    localparam int IDX_W    = $clog2(N_TERMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DED-1:0]   ded_in,
    input  logic [N_FB-1:0]    fb_in,
    input  logic               spare_join,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [N_LINES-1:0] wr_word,
    input  logic               erase,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [N_LINES-1:0] rd_word,
    output logic [N_OUT-1:0]   sum_out,
    output logic [N_OUT-1:0]   oe_term
);
    logic [N_LINES-1:0]         lines;
    logic [N_TERMS*N_LINES-1:0] masks;
    logic [N_TERMS-1:0]         terms;

    sop_line_build #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
        .ded_i   (ded_in),
        .fb_i    (fb_in),
        .lines_o (lines)
    );

    sop_cfg_store #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_word_i (wr_word),
        .erase_i   (erase),
        .rd_idx_i  (rd_idx),
        .rd_word_o (rd_word),
        .masks_o   (masks)
    );

    sop_term_eval #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_terms (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines),
        .masks_i (masks),
        .terms_o (terms)
    );

    sop_or_groups #(.N_OUT(N_OUT), .GRP_TERMS(GRP_TERMS)) u_or (
        .clk          (clk),
        .rst_n        (rst_n),
        .spare_join_i (spare_join),
        .terms_i      (terms),
        .sum_o        (sum_out),
        .oe_o         (oe_term)
    );
endmodule

// File: tb/test_sop_plane.sv
// Bench for sop_plane: behavioural reference model compared on every clock.
module test_sop_plane;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ded_in = '0;
    logic [7:0]  fb_in = '0;
    logic        spare_join = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic        erase = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_word;
    logic [7:0]  sum_out;
    logic [7:0]  oe_term;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    string       tag = "R10";
    logic [31:0] ref_mem [64];

    sop_plane i_sop_plane (
        .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
        .spare_join(spare_join), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .erase(erase), .rd_idx(rd_idx),
        .rd_word(rd_word), .sum_out(sum_out), .oe_term(oe_term)
    );

    always #4 clk = ~clk;

    // reference store: reset, then erase, then write
    always @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int t = 0; t < 64; t++) ref_mem[t] = '0;
        end else if (wr_en) begin
            ref_mem[wr_idx] = wr_word;
        end
    end

    function automatic bit ref_term(input int t);
        bit v = 1'b1;
        for (int j = 0; j < 32; j++) begin
            if (ref_mem[t][j]) begin
                int  s   = j / 2;
                bit  sv  = (s < 8) ? ded_in[s] : fb_in[s-8];
                v = v & ((j % 2 == 0) ? sv : !sv);
            end
        end
        return v;
    endfunction

    task automatic check_one(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] es = '0;
        logic [7:0] eo = '0;
        for (int o = 0; o < 8; o++) begin
            bit any = 1'b0;
            for (int k = 0; k < 7; k++) any = any | ref_term(8*o + k);
            if (spare_join) any = any | ref_term(8*o + 7);
            else eo[o] = ref_term(8*o + 7);
            es[o] = any;
        end
        check_one("sum_out", {24'd0, sum_out}, {24'd0, es});
        check_one("oe_term", {24'd0, oe_term}, {24'd0, eo});
        check_one("rd_word", rd_word, ref_mem[rd_idx]);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
        erase = 1'b0;
    endtask

    task automatic write_row(input int t, input logic [31:0] w);
        wr_en = 1'b1; wr_idx = 6'(t); wr_word = w; rd_idx = 6'(t);
        tick();
    endtask

    task automatic fill_false();
        for (int t = 0; t < 64; t++) write_row(t, 32'h0000_0003);
    endtask

    initial begin
        for (int t = 0; t < 64; t++) ref_mem[t] = '0;
        // R10: reset state, all rows empty; R3: open terms give all-ones sums
        tag = "R10";
        repeat (3) tick();
        rst_n = 1'b1;
        for (int t = 0; t < 64; t += 9) begin rd_idx = 6'(t); tick(); end
        tag = "R3";
        ded_in = 8'h5A; fb_in = 8'hC3; spare_join = 1'b1; tick();
        spare_join = 1'b0; tick();
        spare_join = 1'b1;

        // R4: rows tied to both polarities of one signal, across signals
        tag = "R4";
        for (int t = 0; t < 64; t++) begin
            int s = t % 16;
            write_row(t, (32'h3 << (2*s)) | 32'(($urandom & $urandom) & 32'h5555_5555));
        end
        for (int n = 0; n < 6; n++) begin
            ded_in = 8'($urandom); fb_in = 8'($urandom); spare_join = n[0]; tick();
        end
        fill_false();

        // R1 and R2: a single connected line on term 0 steers sum_out[0]
        tag = "R1";
        for (int j = 0; j < 32; j++) begin
            write_row(0, 32'h1 << j);
            for (int n = 0; n < 3; n++) begin
                ded_in = 8'($urandom); fb_in = 8'($urandom); tick();
            end
        end
        tag = "R2";
        for (int n = 0; n < 20; n++) begin
            write_row(0, 32'($urandom & $urandom & 32'h5555_5555));
            for (int m = 0; m < 4; m++) begin
                ded_in = 8'($urandom); fb_in = 8'($urandom); tick();
            end
        end
        write_row(0, 32'h3);

        // R5, R6, R7: one open term at a time under both spare modes
        for (int t = 0; t < 64; t++) begin
            write_row(t, 32'h0);
            tag = "R5"; tick();
            spare_join = 1'b1; tag = "R6"; tick();
            spare_join = 1'b0; tag = "R7"; tick();
            write_row(t, 32'h3);
        end

        // R8: random rows with readback at random indices
        tag = "R8";
        for (int n = 0; n < 200; n++) begin
            wr_en = ($urandom % 3) != 0;
            wr_idx = 6'($urandom); wr_word = $urandom & $urandom & $urandom;
            rd_idx = ($urandom % 2 == 0) ? wr_idx : 6'($urandom);
            ded_in = 8'($urandom); fb_in = 8'($urandom); spare_join = 1'($urandom);
            tick();
        end

        // R9: erase clears all and wins over a same-cycle write
        tag = "R9";
        erase = 1'b1; tick();
        for (int t = 0; t < 64; t += 7) begin rd_idx = 6'(t); tick(); end
        write_row(12, 32'hFFFF_0000);
        erase = 1'b1; wr_en = 1'b1; wr_idx = 6'd12; wr_word = 32'h0000_00F0; rd_idx = 6'd12;
        tick();
        tick();

        // R11: input changes reach the outputs without a clock edge
        tag = "R11";
        fill_false();
        write_row(8, 32'h0000_0001);
        write_row(15, 32'h0000_0008);
        spare_join = 1'b0;
        for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            #1 ded_in = 8'($urandom);
            #1 compare_all();
            spare_join = ~spare_join;
            #1 compare_all();
        end

        // soak with mixed traffic
        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            wr_en = ($urandom % 4) == 0;
            erase = ($urandom % 200) == 0;
            wr_idx = 6'($urandom); wr_word = $urandom & $urandom & $urandom;
            rd_idx = 6'($urandom);
            ded_in = 8'($urandom); fb_in = 8'($urandom); spare_join = 1'($urandom);
            tick();
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: a hung run ends as a failure
    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule